// File: doc/BRIEF.md
# Output Compare Timer with Counter Reset

This block is a 16-bit up counter driven by the bus clock through a programmable power-of-two prescaler, with eight compare channels. A channel that is switched to compare mode watches the counter. When the counter steps onto the channel's compare value, the channel raises a sticky match flag. It can also act on its own output pin: toggle, clear, set, or do nothing. Software reaches every setting through a small word-wide register port. Flags are cleared by writing ones.

Channel 7 has two extra roles. First, a mask register lets a channel-7 event force chosen pins to levels held in a level register, and this forced level wins over the pin's own action in the same cycle. A masked pin whose action is "do nothing" stays untouched. Second, a wrap option makes the counter return to zero one bus cycle after it reaches the channel-7 compare value. The counter then cycles through 0..C, and the full period is C times the prescale plus one bus cycle.

Top module: `oct_timer`

## Requirements
- R1: After reset the counter, all pins, all flags and all configuration registers read zero.
- R2: With the run bit (CTRL bit 0) set, the counter advances by one every 2^PS bus cycles, where PS is CTRL bits 4:2 (0..7). With run clear, the counter holds its value.
- R3: A write to the counter register (address 6) loads the written value and restarts the prescale phase, so the next step comes a full 2^PS cycles later.
- R4: The overflow flag (flag register bit 8) sets on the step from 0xFFFF to 0.
- R5: With the wrap bit (CTRL bit 1) set and channel-7 compare value C nonzero, the counter runs 0..C. It holds C for exactly one bus cycle, then returns to 0, for a period of C*2^PS+1 cycles. Each such return also sets the overflow flag. With C equal to zero, the counter runs freely.
- R6: A channel whose select bit (register 1, bit i) is 1 sets match flag i (flag register bit i) when the counter steps onto its compare value (address 8+i). Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.
- R7: A selected channel's action field (register 2, bits 2i+1:2i) takes one of these codes: 01 toggles the pin, 10 drives it to 0, 11 drives it to 1. The pin changes one bus cycle after the counter steps onto the compare value.
- R8: Action code 00 leaves the pin unchanged, while the match flag still sets.
- R9: A channel whose select bit is 0 never changes its pin and never sets its match flag.
- R10: When selected channel 7 has an event, every selected channel with mask bit i (register 3) set and a nonzero action takes level bit i (register 4). This takes priority over the channel's own action in the same cycle.
- R11: A mask bit set on a channel whose action is 00 has no effect on that pin when channel 7 has an event.
- R12: Registers 0 to 4 and the compare registers read back what was written. The counter reads at address 6 and the flags at address 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address (bit 3 selects a compare register) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| cnt_o | output | 16 | Current counter value |
| oc_pin | output | 8 | Compare output pins |
| flag_o | output | 9 | Match flags 7:0 and overflow flag (bit 8) |

## Verification
The bench builds the block with its default parameters: eight channels, a 16-bit counter and a three-bit prescale field. This puts every prescale ratio from 1 to 128 within reach, and the bench sweeps each ratio cycle by cycle against floor(m/2^PS). The wrap mode is swept over several channel-7 compare values and prescales, checking the C*2^PS+1 period and the one-cycle dwell on C. Loading 0xFFFE reaches the overflow boundary within a few cycles. The pin tests run two rounds in which the channel-7 forced level and the channel's own action disagree, so that the priority shows on the pin.

// File: rtl/oct_pkg.sv
package oct_pkg;
  // register word addresses (low field of addr)
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_SEL  = 1;
  localparam int unsigned REG_ACT  = 2;
  localparam int unsigned REG_MASK = 3;
  localparam int unsigned REG_LVL  = 4;
  localparam int unsigned REG_FLAG = 5;
  localparam int unsigned REG_CNT  = 6;

  // control bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_WRAP = 1;
  localparam int unsigned CB_PS   = 2;

  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TGL = 2'b01,
    ACT_CLR = 2'b10,
    ACT_SET = 2'b11
  } oc_act_e;
endpackage

// File: rtl/oct_prescale.sv
module oct_prescale #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           restart,
  input  logic [PSW-1:0] ps,
  output logic           tick
);
  localparam int unsigned DW = (1 << PSW) - 1;

  logic [DW-1:0] pc_q, pc_d, lim;

  always_comb begin
    lim  = DW'((1 << ps) - 1);
    tick = run && (pc_q == lim);
    pc_d = pc_q;
    if (restart)      pc_d = '0;
    else if (run)     pc_d = tick ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/oct_counter.sv
module oct_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          wrap_en,
  input  logic [CW-1:0] cmp_top,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt,
  output logic          fresh,
  output logic          wrap_hit,
  output logic          ovf_set
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fresh_q, fresh_d;
  logic          roll;

  always_comb begin
    // counter has just arrived on the top value: leave after this one cycle
    wrap_hit = run && fresh_q && wrap_en && (cmp_top != '0) && (cnt_q == cmp_top);
    roll     = tick && (cnt_q == {CW{1'b1}});
    ovf_set  = !ld && (wrap_hit || roll);
    cnt_d    = cnt_q;
    if (ld)            cnt_d = ld_val;
    else if (wrap_hit) cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + 1'b1;
    fresh_d  = ld || wrap_hit || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
    end
  end

  assign cnt   = cnt_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/oct_channel.sv
module oct_channel
  import oct_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [1:0]    act,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] cnt,
  input  logic          fresh,
  input  logic          ov_hit,
  input  logic          ov_mask,
  input  logic          ov_lvl,
  output logic          ev,
  output logic          pin
);
  logic    pin_q, pin_d;
  oc_act_e mode;

  always_comb begin
    mode  = oc_act_e'(act);
    ev    = fresh && sel && (cnt == cmp);
    pin_d = pin_q;
    if (sel && (mode != ACT_OFF)) begin
      if (ov_hit && ov_mask) pin_d = ov_lvl;
      else if (ev) begin
        unique case (mode)
          ACT_TGL: pin_d = ~pin_q;
          ACT_CLR: pin_d = 1'b0;
          ACT_SET: pin_d = 1'b1;
          default: pin_d = pin_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/oct_timer.sv
module oct_timer
  import oct_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3,
  localparam int unsigned IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned LW  = (IW < 3) ? 3 : IW,
  localparam int unsigned AW  = LW + 1,
  localparam int unsigned BW0 = (CW > 2 * NCH) ? CW : 2 * NCH,
  localparam int unsigned BW  = (BW0 > NCH + 1) ? BW0 : NCH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic [CW-1:0] cnt_o,
  output logic [NCH-1:0] oc_pin,
  output logic [NCH:0]  flag_o
);
  localparam int unsigned TOP = NCH - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // configuration state
  logic            run_q, run_d, wrap_q, wrap_d;
  logic [PSW-1:0]  ps_q, ps_d;
  logic [NCH-1:0]  sel_q, sel_d, mask_q, mask_d, lvl_q, lvl_d;
  logic [2*NCH-1:0] act_q, act_d;
  logic [NCH:0]    flag_q, flag_d, w1c, set_vec;
  logic [CW-1:0]   cmp_q [NCH];
  logic [CW-1:0]   cmp_d [NCH];

  logic [LW-1:0]   ra;
  logic            is_cmp, cnt_ld;
  logic [IW-1:0]   cidx;

  // datapath
  logic            tick, fresh, wrap_hit, ovf_set;
  logic [CW-1:0]   cnt;
  logic [NCH-1:0]  ev, pin;

  assign ra     = addr[LW-1:0];
  assign is_cmp = addr[AW-1];
  assign cidx   = addr[IW-1:0];
  assign cnt_ld = wr_en && !is_cmp && (ra == LW'(REG_CNT));

  always_comb begin
    run_d  = run_q;
    wrap_d = wrap_q;
    ps_d   = ps_q;
    sel_d  = sel_q;
    act_d  = act_q;
    mask_d = mask_q;
    lvl_d  = lvl_q;
    w1c    = '0;
    for (int i = 0; i < NCH; i++) cmp_d[i] = cmp_q[i];
    if (wr_en) begin
      if (is_cmp) begin
        if (int'(cidx) < NCH) cmp_d[cidx] = wdata[CW-1:0];
      end else begin
        unique case (ra)
          LW'(REG_CTRL): begin
            run_d  = wdata[CB_RUN];
            wrap_d = wdata[CB_WRAP];
            ps_d   = wdata[CB_PS +: PSW];
          end
          LW'(REG_SEL):  sel_d  = wdata[NCH-1:0];
          LW'(REG_ACT):  act_d  = wdata[2*NCH-1:0];
          LW'(REG_MASK): mask_d = wdata[NCH-1:0];
          LW'(REG_LVL):  lvl_d  = wdata[NCH-1:0];
          LW'(REG_FLAG): w1c    = wdata[NCH:0];
          default: ;
        endcase
      end
    end
    set_vec = {ovf_set, ev};
    flag_d  = (flag_q & ~w1c) | set_vec;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q  <= 1'b0;
      wrap_q <= 1'b0;
      ps_q   <= '0;
      sel_q  <= '0;
      act_q  <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      flag_q <= '0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else begin
      run_q  <= run_d;
      wrap_q <= wrap_d;
      ps_q   <= ps_d;
      sel_q  <= sel_d;
      act_q  <= act_d;
      mask_q <= mask_d;
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  oct_prescale #(.PSW(PSW)) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (run_q),
    .restart (cnt_ld || wrap_hit),
    .ps      (ps_q),
    .tick    (tick)
  );

  oct_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (run_q),
    .tick     (tick),
    .wrap_en  (wrap_q),
    .cmp_top  (cmp_q[TOP]),
    .ld       (cnt_ld),
    .ld_val   (wdata[CW-1:0]),
    .cnt      (cnt),
    .fresh    (fresh),
    .wrap_hit (wrap_hit),
    .ovf_set  (ovf_set)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    oct_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (srst_n),
      .sel     (sel_q[g]),
      .act     (act_q[2*g +: 2]),
      .cmp     (cmp_q[g]),
      .cnt     (cnt),
      .fresh   (fresh),
      .ov_hit  (ev[TOP]),
      .ov_mask (mask_q[g]),
      .ov_lvl  (lvl_q[g]),
      .ev      (ev[g]),
      .pin     (pin[g])
    );
  end

  always_comb begin
    rdata = '0;
    if (is_cmp) begin
      if (int'(cidx) < NCH) rdata[CW-1:0] = cmp_q[cidx];
    end else begin
      unique case (ra)
        LW'(REG_CTRL): begin
          rdata[CB_RUN]      = run_q;
          rdata[CB_WRAP]     = wrap_q;
          rdata[CB_PS +: PSW] = ps_q;
        end
        LW'(REG_SEL):  rdata[NCH-1:0]   = sel_q;
        LW'(REG_ACT):  rdata[2*NCH-1:0] = act_q;
        LW'(REG_MASK): rdata[NCH-1:0]   = mask_q;
        LW'(REG_LVL):  rdata[NCH-1:0]   = lvl_q;
        LW'(REG_FLAG): rdata[NCH:0]     = flag_q;
        LW'(REG_CNT):  rdata[CW-1:0]    = cnt;
        default: ;
      endcase
    end
  end

  assign cnt_o  = cnt;
  assign oc_pin = pin;
  assign flag_o = flag_q;
endmodule

// File: rtl/oct_timer_chk.sv
module oct_timer_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16
) (
  input logic             clk,
  input logic             srst_n,
  input logic             run,
  input logic             wrap,
  input logic             ld,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    cmp7,
  input logic [NCH-1:0]   sel,
  input logic [2*NCH-1:0] act,
  input logic [NCH-1:0]   pin,
  input logic [NCH:0]     flag
);
  logic [NCH-1:0] off;
  always_comb
    for (int i = 0; i < NCH; i++) off[i] = (act[2*i +: 2] == 2'b00);

  // R5: the top value is held for one cycle only
  p_hold_one_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (run && wrap && !ld && cmp7 != '0 && cnt == cmp7 && !$stable(cnt)) |=> (cnt == '0));

  // R4: a roll from all ones to zero raises the overflow flag
  p_roll_ovf_r4: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(run && !ld && cnt == {CW{1'b1}}) && cnt == '0) |-> flag[NCH]);

  // R2: a stopped counter keeps its value
  p_freeze_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!run && !ld) |=> $stable(cnt));

  // R2: a running counter only steps by one or returns to zero
  p_step_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (run && !ld) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R9: unselected channels keep their pins
  p_unsel_pin_r9: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (((pin ^ $past(pin)) & ~$past(sel)) == '0));

  // R11: disconnected channels keep their pins, mask or not
  p_off_pin_r11: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (((pin ^ $past(pin)) & $past(off)) == '0));
endmodule

bind oct_timer oct_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk    (clk),
  .srst_n (srst_n),
  .run    (run_q),
  .wrap   (wrap_q),
  .ld     (cnt_ld),
  .cnt    (cnt),
  .cmp7   (cmp_q[NCH-1]),
  .sel    (sel_q),
  .act    (act_q),
  .pin    (pin),
  .flag   (flag_q)
);

// File: tb/oct_timer_test.sv
module oct_timer_test;
  localparam int NCH = 8;
  localparam int A_CTRL = 0, A_SEL = 1, A_ACT = 2, A_MASK = 3, A_LVL = 4;
  localparam int A_FLAG = 5, A_CNT = 6, A_CMP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [15:0] cnt_o;
  logic [7:0]  oc_pin;
  logic [8:0]  flag_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  oct_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_o(cnt_o), .oc_pin(oc_pin), .flag_o(flag_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    addr = 4'(a);
    #1;
    v = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, clear flags, load zero, start: counter equals floor(m/P) m edges later
  task automatic arm(input int ps, input int wrap);
    wr(A_CTRL, ps << 2);
    wr(A_FLAG, 'h1FF);
    wr(A_CNT, 0);
    wr(A_CTRL, 1 | (wrap << 1) | (ps << 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 pins", oc_pin, 0);
    chk("R1 flags", flag_o, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CMP + 7, v); chk("R1 cmp7", v, 0);

    // R12 readback
    wr(A_SEL, 'hA5);     rd(A_SEL, v);     chk("R12 sel", v, 'hA5);
    wr(A_ACT, 'h1234);   rd(A_ACT, v);     chk("R12 act", v, 'h1234);
    wr(A_MASK, 'h3C);    rd(A_MASK, v);    chk("R12 mask", v, 'h3C);
    wr(A_LVL, 'h81);     rd(A_LVL, v);     chk("R12 lvl", v, 'h81);
    wr(A_CMP + 3, 'hBEEF); rd(A_CMP + 3, v); chk("R12 cmp3", v, 'hBEEF);
    wr(A_CTRL, 'h1C);    rd(A_CTRL, v);    chk("R12 ctrl", v, 'h1C);
    wr(A_CTRL, 0); wr(A_SEL, 0); wr(A_ACT, 0); wr(A_MASK, 0); wr(A_LVL, 0);
    wr(A_CMP + 3, 0);

    // R2 prescale sweep over every ratio
    for (int ps = 0; ps < 8; ps++) begin
      arm(ps, 0);
      for (int m = 0; m < 3 * (1 << ps); m++) begin
        chk($sformatf("R2 ps=%0d m=%0d", ps, m), cnt_o, m >> ps);
        step(1);
      end
    end

    // R2 frozen when stopped
    wr(A_CTRL, 0);
    held = cnt_o;
    step(10);
    chk("R2 hold", cnt_o, held);

    // R3 load restarts the prescale phase (ps=1)
    wr(A_CTRL, 1 | (1 << 2));
    step(1);
    wr(A_CNT, 'h1234);
    chk("R3 load", cnt_o, 'h1234);
    step(1); chk("R3 no early step", cnt_o, 'h1234);
    step(1); chk("R3 step", cnt_o, 'h1235);
    rd(A_CNT, v); chk("R12 cnt read", v, 'h1235);

    // R4 overflow
    wr(A_CTRL, 0);
    wr(A_FLAG, 'h1FF);
    wr(A_CNT, 'hFFFE);
    wr(A_CTRL, 1);
    step(1); chk("R4 at FFFF", cnt_o, 'hFFFF); chk("R4 flag low", flag_o[8], 0);
    step(1); chk("R4 rolled", cnt_o, 0);       chk("R4 flag set", flag_o[8], 1);
    rd(A_FLAG, v); chk("R12 flag read", v, 'h100);
    wr(A_FLAG, 0);     chk("R6 write0 keeps", flag_o[8], 1);
    wr(A_FLAG, 'h100); chk("R6 w1c", flag_o[8], 0);

    // R5 wrap on channel-7 match
    for (int ps = 0; ps < 3; ps++) begin
      for (int k = 0; k < 3; k++) begin
        int c, per;
        c = (k == 0) ? 1 : (k == 1) ? 3 : 6;
        per = c * (1 << ps) + 1;
        wr(A_CTRL, 0);
        wr(A_CMP + 7, c);
        arm(ps, 1);
        for (int m = 0; m < 2 * per; m++) begin
          int t;
          t = m % per;
          chk($sformatf("R5 ps=%0d c=%0d m=%0d", ps, c, m), cnt_o,
              (t < c * (1 << ps)) ? (t >> ps) : c);
          step(1);
        end
      end
    end
    wr(A_CTRL, 0);
    wr(A_CMP + 7, 3);
    arm(0, 1);
    step(3); chk("R5 ovf not yet", flag_o[8], 0);
    step(1); chk("R5 wrapped", cnt_o, 0); chk("R5 ovf on wrap", flag_o[8], 1);
    wr(A_CTRL, 0);
    wr(A_CMP + 7, 0);
    arm(0, 1);
    step(10); chk("R5 zero top free-runs", cnt_o, 10);

    // R6..R9 channel actions
    wr(A_CTRL, 0);
    wr(A_SEL, 'h0F);
    wr(A_ACT, 'h337);
    wr(A_CMP + 0, 2); wr(A_CMP + 1, 4); wr(A_CMP + 2, 6);
    wr(A_CMP + 3, 3); wr(A_CMP + 4, 3);
    arm(0, 0);
    step(2); chk("R7 set not yet", oc_pin[0], 0);
    step(1); chk("R7 set", oc_pin[0], 1); chk("R6 flag0", flag_o[0], 1);
    step(1); chk("R8 off flag", flag_o[3], 1); chk("R8 off pin", oc_pin[3], 0);
    step(1); chk("R7 toggle", oc_pin[1], 1);
    chk("R9 unsel pin", oc_pin[4], 0); chk("R9 unsel flag", flag_o[4], 0);
    step(2); chk("R7 set ch2", oc_pin[2], 1);
    wr(A_ACT, 'h327);
    wr(A_CMP + 2, 40);
    while (cnt_o != 16'd40) step(1);
    chk("R7 clear not yet", oc_pin[2], 1);
    step(1); chk("R7 clear", oc_pin[2], 0);
    wr(A_FLAG, 'h001);
    chk("R6 w1c flag0", flag_o[0], 0); chk("R6 other flag kept", flag_o[3], 1);

    // R10/R11 channel-7 override, round 1: own action set, forced level 0
    wr(A_CTRL, 0);
    wr(A_SEL, 'h8D);
    wr(A_ACT, 'h33);
    wr(A_MASK, 'h09);
    wr(A_LVL, 'h08);
    wr(A_CMP + 0, 5); wr(A_CMP + 2, 5); wr(A_CMP + 3, 5); wr(A_CMP + 7, 5);
    arm(0, 0);
    step(6);
    chk("R10 override beats set", oc_pin[0], 0);
    chk("R10 unmasked acts", oc_pin[2], 1);
    chk("R11 masked off pin", oc_pin[3], 0);
    chk("R6 flag7", flag_o[7], 1);
    // round 2: own action clear, forced level 1
    wr(A_CTRL, 0);
    wr(A_ACT, 'h32);
    wr(A_LVL, 'h09);
    arm(0, 0);
    step(6);
    chk("R10 override beats clear", oc_pin[0], 1);
    chk("R11 masked off pin r2", oc_pin[3], 0);
    chk("R9 pin7 off", oc_pin[7], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule